// File: doc/BRIEF.md
# HDMI Vendor Block Extended-Format Scanner

This block takes one 128-byte extension of a display's capability data, streamed in one byte per accepted cycle. A start marker restarts the capture. Once the last byte has been stored, a sequential walker steps through the collection of data blocks. It looks for the vendor block that announces HDMI capability.

When that block declares that HDMI video fields are present, the scanner does four things:
- It finds the field holding the 3D and extended-format information. The position of this field moves with the latency-present bits.
- It reports the 3D flag and the multi-3D field.
- It emits each extended video code, renumbered into a private format range, on a valid/data output.
- It ends every extension with a single done pulse, together with an error flag or an absent flag.

A display controller uses the emitted format numbers to add the high-resolution extended modes to its list of supported timings.

Top module: `cea_vendor_scan`

## Requirements
- R1: A byte with `in_valid` and `in_sop` high is stored as byte 0. The next 127 bytes that have `in_valid` high fill bytes 1 to 127, and cycles with `in_valid` low are skipped. A new `in_sop` restarts the capture. Parsing starts only after byte 127 has been stored, so a partial extension gives neither a done pulse nor any codes.
- R2: The walk starts at byte 4. Each header byte carries a tag in bits 7:5 and a payload length L in bits 4:0. A block with any tag other than 3 is stepped over to the byte at header+L+1, and the first tag-3 block is taken as the vendor block.
- R3: Byte 2 of the extension gives the walk limit, clipped to 128. If the walk reaches the limit without a vendor block, absent is reported. If a header at position p has p+L at or beyond the limit, err is reported.
- R4: If no vendor block is found, or it has L below 9, the scanner reports absent and emits no codes.
- R5: If bit 5 of vendor byte 8 (header+8) is clear, the scanner reports absent with no codes. Whenever err or absent is reported, has_3d and multi_3d are 0.
- R6: The field offset B, relative to the header, depends on bits 7 and 6 of vendor byte 8. It is 9 when bit 7 is 0, 11 when bits 7:6 are 10, and 13 when bits 7:6 are 11.
- R7: has_3d takes bit 7 of the byte at header+B, and multi_3d takes bits 6:5 of that byte.
- R8: The code count N is bits 7:5 of the byte at header+B+1. The N raw codes start at header+B+2. Each code is output, in address order on consecutive cycles, as 127 plus the raw value.
- R9: If B+1 exceeds L, or B+1+N exceeds L, the scanner reports err and emits no codes.
- R10: done is high for exactly one cycle per extension, and it shares its cycle with the last code. When N is 0, done comes without any code. err, absent, has_3d and multi_3d hold from done until the next parse starts.
- R11: While reset is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | Marks byte 0 of an extension |
| in_byte | input | 8 | Extension byte |
| fmt_valid | output | 1 | Extended format number valid |
| fmt_num | output | 9 | Private format number (127 + raw code) |
| done | output | 1 | One-cycle end-of-parse pulse |
| err | output | 1 | Malformed block layout |
| absent | output | 1 | No usable vendor block or video fields |
| has_3d | output | 1 | 3D-present flag |
| multi_3d | output | 2 | Multi-3D-present field |

## Verification
The last extended code and the done pulse share one cycle, so an off-by-one in the code counter shows up either as a lost code or as a done that comes late or early. Vectors with one, three, four and seven codes provoke this overlap, and a vector with zero codes shows done with no code. A monitor sampling on the falling edge records every code. It also notes whether fmt_valid was high in the cycle of done, and the bench compares that record, the code count and each value with the table's expected results.

// File: rtl/evp_pkg.sv
package evp_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_WALK,
      PS_B8,
      PS_FLAG,
      PS_CNT,
      PS_EMIT
   } pstate_t;

   // relative field offsets selected by the latency-present bits
   localparam int OFS_NO_LAT  = 9;
   localparam int OFS_ONE_LAT = 11;
   localparam int OFS_TWO_LAT = 13;

   // bit positions inside vendor byte 8
   localparam int HVP_BIT  = 5;
   localparam int ILAT_BIT = 6;
   localparam int LAT_BIT  = 7;

endpackage

// File: rtl/evp_capture.sv
module evp_capture #(
   parameter int DEPTH   = 128,
   parameter int LIM_IDX = 2,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic [7:0]    in_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [7:0]    lim_byte,
   output logic          full
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_idx;
   logic          filling;
   logic          wr_en;
   logic [AW-1:0] wr_addr;

   always_comb begin
      wr_en   = accept && in_valid && (in_sop || filling);
      wr_addr = in_sop ? '0 : wr_idx;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= in_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx  <= '0;
         filling <= 1'b0;
         full    <= 1'b0;
      end else begin
         full <= 1'b0;
         if (wr_en) begin
            if (in_sop) begin
               wr_idx  <= AW'(1);
               filling <= 1'b1;
            end else if (wr_idx == LAST) begin
               wr_idx  <= '0;
               filling <= 1'b0;
               full    <= 1'b1;
            end else begin
               wr_idx <= wr_idx + AW'(1);
            end
         end
      end
   end

   assign rd_data  = mem[rd_addr];
   assign lim_byte = mem[LIM_IDX];

endmodule

// File: rtl/evp_base.sv
module evp_base
   import evp_pkg::*;
(
   input  logic [7:0] cap_byte,
   output logic [5:0] rel_ofs
);

   always_comb begin
      if (!cap_byte[LAT_BIT])       rel_ofs = 6'(OFS_NO_LAT);
      else if (!cap_byte[ILAT_BIT]) rel_ofs = 6'(OFS_ONE_LAT);
      else                          rel_ofs = 6'(OFS_TWO_LAT);
   end

endmodule

// File: rtl/evp_walker.sv
module evp_walker
   import evp_pkg::*;
#(
   parameter int DEPTH      = 128,
   parameter int FMT_W      = 9,
   parameter int FMT_BASE   = 127,
   parameter int TAG_VS     = 3,
   parameter int MIN_LEN    = 9,
   parameter int WALK_START = 4,
   localparam int AW        = $clog2(DEPTH),
   localparam int PW        = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       lim_byte,
   input  logic [7:0]       rd_data,
   input  logic [5:0]       base_rel,
   output logic [AW-1:0]    rd_addr,
   output logic             busy,
   output logic             fmt_valid,
   output logic [FMT_W-1:0] fmt_num,
   output logic             done,
   output logic             err,
   output logic             absent,
   output logic             has_3d,
   output logic [1:0]       multi_3d
);

   pstate_t       state, nxt;
   logic [PW-1:0] ptr, lim;
   logic [AW-1:0] vs;
   logic [4:0]    vlen;
   logic [5:0]    base;
   logic [2:0]    cnt, idx;
   logic          t3d;
   logic [1:0]    tmul;

   logic [2:0]    hdr_tag;
   logic [4:0]    hdr_len;
   logic [PW:0]   blk_end;
   logic [2:0]    cnt_f;
   logic          fin, fin_err, fin_abs, emit, step, ld_vs, ld_flags, ld_cnt;

   always_comb begin
      hdr_tag = rd_data[7:5];
      hdr_len = rd_data[4:0];
      cnt_f   = rd_data[7:5];
      blk_end = {1'b0, ptr} + (PW+1)'(hdr_len);
   end

   always_comb begin
      case (state)
         PS_WALK: rd_addr = ptr[AW-1:0];
         PS_B8:   rd_addr = vs + AW'(8);
         PS_FLAG: rd_addr = vs + AW'(base);
         PS_CNT:  rd_addr = vs + AW'(base) + AW'(1);
         PS_EMIT: rd_addr = vs + AW'(base) + AW'(2) + AW'(idx);
         default: rd_addr = '0;
      endcase
   end

   always_comb begin
      nxt      = state;
      fin      = 1'b0;
      fin_err  = 1'b0;
      fin_abs  = 1'b0;
      emit     = 1'b0;
      step     = 1'b0;
      ld_vs    = 1'b0;
      ld_flags = 1'b0;
      ld_cnt   = 1'b0;
      case (state)
         PS_IDLE: if (start) nxt = PS_WALK;
         PS_WALK: begin
            if (ptr >= lim) begin
               fin = 1'b1; fin_abs = 1'b1; nxt = PS_IDLE;
            end else if (blk_end >= {1'b0, lim}) begin
               fin = 1'b1; fin_err = 1'b1; nxt = PS_IDLE;
            end else if (hdr_tag == 3'(TAG_VS)) begin
               if (hdr_len < 5'(MIN_LEN)) begin
                  fin = 1'b1; fin_abs = 1'b1; nxt = PS_IDLE;
               end else begin
                  ld_vs = 1'b1; nxt = PS_B8;
               end
            end else begin
               step = 1'b1;
            end
         end
         PS_B8: begin
            if (!rd_data[HVP_BIT]) begin
               fin = 1'b1; fin_abs = 1'b1; nxt = PS_IDLE;
            end else if (7'(base_rel) + 7'd1 > 7'(vlen)) begin
               fin = 1'b1; fin_err = 1'b1; nxt = PS_IDLE;
            end else begin
               nxt = PS_FLAG;
            end
         end
         PS_FLAG: begin
            ld_flags = 1'b1; nxt = PS_CNT;
         end
         PS_CNT: begin
            if (7'(base) + 7'd1 + 7'(cnt_f) > 7'(vlen)) begin
               fin = 1'b1; fin_err = 1'b1; nxt = PS_IDLE;
            end else if (cnt_f == 3'd0) begin
               fin = 1'b1; nxt = PS_IDLE;
            end else begin
               ld_cnt = 1'b1; nxt = PS_EMIT;
            end
         end
         PS_EMIT: begin
            emit = 1'b1;
            if (idx == 3'(cnt - 3'd1)) begin
               fin = 1'b1; nxt = PS_IDLE;
            end
         end
         default: nxt = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= PS_IDLE;
         ptr       <= '0;
         lim       <= '0;
         vs        <= '0;
         vlen      <= '0;
         base      <= '0;
         cnt       <= '0;
         idx       <= '0;
         t3d       <= 1'b0;
         tmul      <= '0;
         fmt_valid <= 1'b0;
         fmt_num   <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         absent    <= 1'b0;
         has_3d    <= 1'b0;
         multi_3d  <= '0;
      end else begin
         state     <= nxt;
         done      <= fin;
         fmt_valid <= emit;
         if (state == PS_IDLE && start) begin
            ptr      <= PW'(WALK_START);
            if (int'(lim_byte) > DEPTH) lim <= PW'(DEPTH);
            else                        lim <= PW'(lim_byte);
            err      <= 1'b0;
            absent   <= 1'b0;
            has_3d   <= 1'b0;
            multi_3d <= '0;
         end
         if (step) ptr <= PW'(blk_end + (PW+1)'(1));
         if (ld_vs) begin
            vs   <= ptr[AW-1:0];
            vlen <= hdr_len;
         end
         if (state == PS_B8) base <= base_rel;
         if (ld_flags) begin
            t3d  <= rd_data[7];
            tmul <= rd_data[6:5];
         end
         if (ld_cnt) begin
            cnt <= cnt_f;
            idx <= '0;
         end
         if (emit) begin
            idx     <= idx + 3'd1;
            fmt_num <= FMT_W'(FMT_BASE) + FMT_W'(rd_data);
         end
         if (fin) begin
            err      <= fin_err;
            absent   <= fin_abs;
            has_3d   <= !fin_err && !fin_abs && t3d;
            multi_3d <= (!fin_err && !fin_abs) ? tmul : 2'b00;
         end
      end
   end

   assign busy = (state != PS_IDLE);

endmodule

// File: rtl/cea_vendor_scan.sv
module cea_vendor_scan #(
   parameter int DEPTH      = 128,
   parameter int FMT_W      = 9,
   parameter int FMT_BASE   = 127,
   parameter int TAG_VS     = 3,
   parameter int MIN_LEN    = 9,
   parameter int WALK_START = 4,
   parameter int LIM_IDX    = 2,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [7:0]       in_byte,
   output logic             fmt_valid,
   output logic [FMT_W-1:0] fmt_num,
   output logic             done,
   output logic             err,
   output logic             absent,
   output logic             has_3d,
   output logic [1:0]       multi_3d
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if ((1 << FMT_W) <= FMT_BASE + 255) begin : g_bad_fmt
      $error("FMT_W too narrow for FMT_BASE plus an 8-bit code");
   end
   if (WALK_START >= DEPTH || LIM_IDX >= WALK_START) begin : g_bad_ofs
      $error("walk start or limit index out of range");
   end

   logic          full, busy;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data, lim_byte;
   logic [5:0]    base_rel;

   evp_capture #(.DEPTH(DEPTH), .LIM_IDX(LIM_IDX)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (!busy && !full),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_byte  (in_byte),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .lim_byte (lim_byte),
      .full     (full)
   );

   evp_base u_base (
      .cap_byte (rd_data),
      .rel_ofs  (base_rel)
   );

   evp_walker #(
      .DEPTH(DEPTH), .FMT_W(FMT_W), .FMT_BASE(FMT_BASE),
      .TAG_VS(TAG_VS), .MIN_LEN(MIN_LEN), .WALK_START(WALK_START)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (full),
      .lim_byte  (lim_byte),
      .rd_data   (rd_data),
      .base_rel  (base_rel),
      .rd_addr   (rd_addr),
      .busy      (busy),
      .fmt_valid (fmt_valid),
      .fmt_num   (fmt_num),
      .done      (done),
      .err       (err),
      .absent    (absent),
      .has_3d    (has_3d),
      .multi_3d  (multi_3d)
   );

endmodule

// File: rtl/cea_vendor_scan_chk.sv
module cea_vendor_scan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fmt_valid,
   input logic       done,
   input logic       err,
   input logic       absent,
   input logic       has_3d,
   input logic [1:0] multi_3d,
   input logic       busy
);

   // R10: done is a single-cycle pulse
   a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: no code follows the done pulse
   a_r10_done_ends_codes: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !fmt_valid);

   // R5: flags cleared whenever the result is err or absent
   a_r5_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (err || absent)) |-> (!has_3d && multi_3d == 2'b00));

   // R9: err and absent never reported together
   a_r9_err_or_absent: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(err && absent));

   // R8: codes other than the last appear only while parsing
   a_r8_codes_in_parse: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_valid && !done) |-> busy);

   // R1: an idle scanner emits no code in the next cycle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !fmt_valid);

endmodule

bind cea_vendor_scan cea_vendor_scan_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fmt_valid (fmt_valid),
   .done      (done),
   .err       (err),
   .absent    (absent),
   .has_3d    (has_3d),
   .multi_3d  (multi_3d),
   .busy      (busy)
);

// File: tb/sim_cea_vendor_scan.sv
module sim_cea_vendor_scan;

   typedef struct packed {
      logic       pre_en;
      logic [4:0] pre_len;
      logic [2:0] tag;
      logic [4:0] len;
      logic [7:0] b8;
      logic [3:0] base;
      logic [7:0] fb;
      logic [7:0] cb;
      logic [7:0] dtd;
      logic       e_err;
      logic       e_abs;
      logic       e_h3d;
      logic [1:0] e_mul;
      logic [2:0] e_n;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{1'b0,5'd0,3'd3,5'd13,8'h20,4'd9 ,8'hC0,8'h60,8'h40,1'b0,1'b0,1'b1,2'd2,3'd3},
      '{1'b1,5'd5,3'd3,5'd13,8'hA0,4'd11,8'h20,8'h20,8'h60,1'b0,1'b0,1'b0,2'd1,3'd1},
      '{1'b0,5'd0,3'd3,5'd18,8'hE0,4'd13,8'h80,8'h80,8'h50,1'b0,1'b0,1'b1,2'd0,3'd4},
      '{1'b0,5'd0,3'd3,5'd10,8'h20,4'd9 ,8'h00,8'h00,8'h40,1'b0,1'b0,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd15,8'hC0,4'd9 ,8'hE0,8'h60,8'h40,1'b0,1'b1,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd2,5'd12,8'h20,4'd9 ,8'hC0,8'h60,8'h20,1'b0,1'b1,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd8 ,8'h20,4'd9 ,8'hC0,8'h20,8'h40,1'b0,1'b1,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd20,8'h20,4'd9 ,8'hC0,8'h20,8'h14,1'b1,1'b0,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd12,8'h20,4'd9 ,8'hC0,8'h80,8'h40,1'b1,1'b0,1'b0,2'd0,3'd0},
      '{1'b1,5'd5,3'd3,5'd13,8'h20,4'd9 ,8'hC0,8'h20,8'h0A,1'b0,1'b1,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd10,8'hA0,4'd11,8'hC0,8'h20,8'h40,1'b1,1'b0,1'b0,2'd0,3'd0},
      '{1'b0,5'd0,3'd3,5'd21,8'hE0,4'd13,8'hE0,8'hE0,8'h7F,1'b0,1'b0,1'b1,2'd3,3'd7}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sop = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       fmt_valid, done, err, absent, has_3d;
   logic [8:0] fmt_num;
   logic [1:0] multi_3d;

   cea_vendor_scan u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_byte(in_byte), .fmt_valid(fmt_valid), .fmt_num(fmt_num),
      .done(done), .err(err), .absent(absent), .has_3d(has_3d),
      .multi_3d(multi_3d)
   );

   always #5 clk = ~clk;

   int         n_tests = 0;
   int         n_fail = 0;
   int         cyc = 0;
   int         done_cnt = 0;
   int         code_cnt = 0;
   logic       last_coinc = 1'b0;
   logic [8:0] codes [16];
   logic [7:0] img [128];

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (fmt_valid) begin
            if (code_cnt < 16) codes[code_cnt] = fmt_num;
            code_cnt = code_cnt + 1;
         end
         if (done) begin
            done_cnt = done_cnt + 1;
            last_coinc = fmt_valid;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_tests = n_tests + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic logic [7:0] raw_code(int k);
      return 8'(1 + 5 * k);
   endfunction

   function automatic string vreq(int i);
      case (i)
         0: return "R2/R6/R8 base 9";
         1: return "R2/R6 skipped block, base 11";
         2: return "R6 base 13";
         3: return "R8 zero codes";
         4: return "R5 video flag clear";
         5: return "R4/R2 no vendor tag";
         6: return "R4 short block";
         7: return "R3 overrun";
         8: return "R9 codes past length";
         9: return "R3 limit stop";
         10: return "R9 field past length";
         default: return "R8 seven codes";
      endcase
   endfunction

   task automatic check_eq(string req, string what, int act, int exp);
      n_tests = n_tests + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic build(vec_t v);
      int p;
      for (int i = 0; i < 128; i++) img[i] = 8'h00;
      img[0] = 8'h02;
      img[1] = 8'h03;
      img[2] = v.dtd;
      p = 4;
      if (v.pre_en) begin
         img[4] = {3'd2, v.pre_len};
         p = 5 + int'(v.pre_len);
      end
      img[p] = {v.tag, v.len};
      img[p + 8] = v.b8;
      img[p + int'(v.base)] = v.fb;
      img[p + int'(v.base) + 1] = v.cb;
      for (int k = 0; k < int'(v.cb[7:5]); k++)
         img[p + int'(v.base) + 2 + k] = raw_code(k);
   endtask

   task automatic clear_mon();
      @(posedge clk); #2;
      done_cnt = 0;
      code_cnt = 0;
      last_coinc = 1'b0;
   endtask

   task automatic send(int nbytes, bit gaps);
      for (int i = 0; i < nbytes; i++) begin
         @(posedge clk); #2;
         if (gaps && i[0]) begin
            in_valid = 1'b0;
            in_sop = 1'b0;
            @(posedge clk); #2;
         end
         in_valid = 1'b1;
         in_sop = (i == 0);
         in_byte = img[i];
      end
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_sop = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (done_cnt == 0 && t < 500) begin
         @(posedge clk);
         t++;
      end
      repeat (10) @(posedge clk);
      #2;
   endtask

   task automatic judge(vec_t v, string req);
      check_eq(req, "R10 done pulses", done_cnt, 1);
      check_eq(req, "R3/R9 err", int'(err), int'(v.e_err));
      check_eq(req, "R4/R5 absent", int'(absent), int'(v.e_abs));
      check_eq(req, "R7 has_3d", int'(has_3d), int'(v.e_h3d));
      check_eq(req, "R7 multi_3d", int'(multi_3d), int'(v.e_mul));
      check_eq(req, "R8 code count", code_cnt, int'(v.e_n));
      for (int k = 0; k < int'(v.e_n) && k < code_cnt && k < 16; k++)
         check_eq(req, "R8 code value", int'(codes[k]), 127 + int'(raw_code(k)));
      if (v.e_n != 3'd0)
         check_eq(req, "R10 done with last code", int'(last_coinc), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      check_eq("R11", "fmt_valid", int'(fmt_valid), 0);
      check_eq("R11", "done", int'(done), 0);
      check_eq("R11", "err/absent", int'({err, absent}), 0);
      check_eq("R11", "3d flags", int'({has_3d, multi_3d}), 0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         build(VT[i]);
         clear_mon();
         send(128, 1'b0);
         wait_done();
         judge(VT[i], vreq(i));
      end

      // R1: valid gaps between bytes
      build(VT[0]);
      clear_mon();
      send(128, 1'b1);
      wait_done();
      judge(VT[0], "R1 gapped input");

      // R1: partial extension followed by a restart
      build(VT[7]);
      clear_mon();
      send(40, 1'b0);
      repeat (60) @(posedge clk);
      #2;
      check_eq("R1 partial", "done pulses", done_cnt, 0);
      check_eq("R1 partial", "codes", code_cnt, 0);
      build(VT[2]);
      send(128, 1'b0);
      wait_done();
      judge(VT[2], "R1 restart");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule